// File: doc/BRIEF.md
# Motor Commutation Track Generator

This block turns a 12-bit absolute shaft angle into three square-wave commutation tracks, U, V and W, for a brushless motor controller. The three tracks each have a 50% duty cycle and are spaced 120 electrical degrees apart. With the pole select bit clear, the six-step pattern repeats once per mechanical turn. With the bit set, it repeats twice per turn.

An 8-bit zero register places the rising edge of U at any of 192 positions, spaced 1.875 degrees apart. A direction bit mirrors the angle before decoding, so changing it reverses the U/V/W order.

The angle is first reduced to an electrical index from 0 to 191. The offset is then subtracted and the tracks are decoded from the result. The tracks are registered and load only on cycles that carry a valid angle sample, so they can change at most once per sample and never glitch.

Top module: `comm_track_gen`

## Requirements
- R1: After reset, trk_u, trk_v and trk_w are all 0 and stay 0 until the first cycle with angle_vld high.
- R2: The tracks take the value decoded from the inputs present on a clock edge where angle_vld is 1, and they show it from that edge on. On edges where angle_vld is 0 they keep their value, whatever the other inputs do.
- R3: The base index is (A × 192) >> 12, where A is the direction-adjusted angle. This gives a value from 0 to 191.
- R4: With e the final index, U is 1 for e = 0..95, V is 1 for e = 64..159, and W is 1 for e = 128..191 or e = 0..31. After the first valid sample, the tracks never read 000 or 111.
- R5: An offset value z from 0x00 to 0xBF is subtracted from the base index modulo 192. For example, z = 0x20 moves the rising edge of U to base index 32.
- R6: An offset value from 0xC0 to 0xFF acts as that value minus 0xC0. For example, 0xC5 behaves as 0x05.
- R7: With pole_four = 0, e is the offset-corrected index. With pole_four = 1, e is twice that index modulo 192, so the pattern occurs twice per turn.
- R8: With dir_cw = 1, A is (4096 − angle) mod 4096. With dir_cw = 0, A is the angle unchanged. Stepping the angle upward with dir_cw = 1 walks the six-step sequence in reverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| angle_vld | input | 1 | Angle sample valid; the tracks load on this cycle |
| angle | input | 12 | Absolute mechanical angle, 4096 counts per turn |
| dir_cw | input | 1 | 1 = mirror the angle (reverse counting direction) |
| pole_four | input | 1 | 0 = two-pole pattern, 1 = four-pole pattern |
| zero_ofs | input | 8 | Position of the U rising edge, in 1.875-degree steps |
| trk_u | output | 1 | Commutation track U |
| trk_v | output | 1 | Commutation track V |
| trk_w | output | 1 | Commutation track W |

## Verification
Two corrections can meet in the same sample: the wrap of an out-of-range offset and the borrow of the modulo-192 subtraction. Four-pole doubling can add a second wrap on top of these. The bench provokes this by pairing offsets at or above 0xC0 with angles whose base index lies below the reduced offset. It runs these cases in both pole modes and both directions. A model written from the requirements computes the expected tracks, and the bench compares them one cycle after each valid sample, at the boundary indices 31/32, 95/96 and 191/0.

// File: rtl/comm_pkg.sv
package comm_pkg;
  localparam int ANGLE_W = 12;
  localparam int OFS_W   = 8;
  localparam int STEPS   = 192;
  localparam int IDX_W   = 8;
  localparam int NTRK    = 3;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [NTRK-1:0]  trk_t;
endpackage

// File: rtl/comm_rst_sync.sv
module comm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/comm_angle_scale.sv
module comm_angle_scale
  import comm_pkg::*;
#(
  parameter int AW    = ANGLE_W,
  parameter int NSTEP = STEPS,
  parameter int IW    = IDX_W
) (
  input  logic [AW-1:0] angle,
  input  logic          dir_cw,
  output logic [IW-1:0] base_idx
);
  localparam int PROD_W = AW + IW;

  logic [AW-1:0]     ang_adj;
  logic [PROD_W-1:0] prod;

  // Mirror the angle for the reversed direction (two's complement wrap).
  always_comb begin
    if (dir_cw) ang_adj = AW'(~angle + AW'(1));
    else        ang_adj = angle;
  end

  always_comb begin
    prod     = {{IW{1'b0}}, ang_adj} * PROD_W'(NSTEP);
    base_idx = prod[PROD_W-1:AW];
  end

  always_comb begin
    assert_idx_range_R3: assert (int'(base_idx) < NSTEP)
      else $error("base index out of range");
  end
endmodule

// File: rtl/comm_ofs_wrap.sv
module comm_ofs_wrap
  import comm_pkg::*;
#(
  parameter int OW    = OFS_W,
  parameter int NSTEP = STEPS,
  parameter int IW    = IDX_W
) (
  input  logic [OW-1:0] zero_ofs,
  output logic [IW-1:0] ofs_red
);
  localparam int OWX = (OW > IW) ? OW : IW;

  logic [OWX-1:0] ofs_x;

  always_comb begin
    ofs_x = OWX'(zero_ofs);
    if (int'(ofs_x) >= NSTEP) ofs_x = ofs_x - OWX'(NSTEP);
    ofs_red = IW'(ofs_x);
  end

  always_comb begin
    assert_ofs_reduced_R6: assert (int'(ofs_red) < NSTEP)
      else $error("reduced offset out of range");
  end
endmodule

// File: rtl/comm_track_decode.sv
module comm_track_decode
  import comm_pkg::*;
#(
  parameter int NSTEP = STEPS,
  parameter int IW    = IDX_W,
  parameter int NT    = NTRK
) (
  input  logic [IW-1:0] base_idx,
  input  logic [IW-1:0] ofs_red,
  input  logic          pole_four,
  output logic [NT-1:0] trk
);
  localparam int HALF = NSTEP / 2;
  localparam int XW   = IW + 1;

  logic [XW-1:0] diff;
  logic [XW-1:0] dbl;
  logic [IW-1:0] eidx;

  // Offset subtraction modulo NSTEP.
  always_comb begin
    if (base_idx >= ofs_red) diff = XW'(base_idx) - XW'(ofs_red);
    else                     diff = XW'(base_idx) + XW'(NSTEP) - XW'(ofs_red);
  end

  // Pole multiplication: double the index modulo NSTEP for four poles.
  always_comb begin
    dbl = {diff[XW-2:0], 1'b0};
    if (int'(dbl) >= NSTEP) dbl = dbl - XW'(NSTEP);
    if (pole_four) eidx = IW'(dbl);
    else           eidx = IW'(diff);
  end

  // One comparator per track, each track shifted by NSTEP/NT more.
  for (genvar k = 0; k < NT; k++) begin : g_trk
    localparam int SHIFT = (k * NSTEP) / NT;
    logic [XW-1:0] rel;
    always_comb begin
      if (int'(eidx) >= SHIFT) rel = XW'(eidx) - XW'(SHIFT);
      else                     rel = XW'(eidx) + XW'(NSTEP - SHIFT);
      trk[k] = (int'(rel) < HALF);
    end
  end

  always_comb begin
    assert_eidx_range_R7: assert (int'(eidx) < NSTEP)
      else $error("electrical index out of range");
  end
endmodule

// File: rtl/comm_track_gen.sv
module comm_track_gen
  import comm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               angle_vld,
  input  logic [ANGLE_W-1:0] angle,
  input  logic               dir_cw,
  input  logic               pole_four,
  input  logic [OFS_W-1:0]   zero_ofs,
  output logic               trk_u,
  output logic               trk_v,
  output logic               trk_w
);
  logic rst_sync_n;
  idx_t base_idx;
  idx_t ofs_red;
  trk_t trk_dec;
  trk_t trk_q;
  trk_t trk_d;
  logic seen_q;
  logic seen_d;

  comm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  comm_angle_scale u_scale (
    .angle    (angle),
    .dir_cw   (dir_cw),
    .base_idx (base_idx)
  );

  comm_ofs_wrap u_ofs (
    .zero_ofs (zero_ofs),
    .ofs_red  (ofs_red)
  );

  comm_track_decode u_dec (
    .base_idx  (base_idx),
    .ofs_red   (ofs_red),
    .pole_four (pole_four),
    .trk       (trk_dec)
  );

  // Next-state: load only on a valid sample.
  always_comb begin
    trk_d  = trk_q;
    seen_d = seen_q;
    if (angle_vld) begin
      trk_d  = trk_dec;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      trk_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      trk_q  <= trk_d;
      seen_q <= seen_d;
    end
  end

  assign trk_u = trk_q[0];
  assign trk_v = trk_q[1];
  assign trk_w = trk_q[2];

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !seen_q |-> (trk_q == '0))
    else $error("tracks nonzero before first sample");

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !angle_vld |=> $stable(trk_q))
    else $error("tracks moved without valid sample");

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    angle_vld |=> (trk_q == $past(trk_dec)))
    else $error("tracks did not load decoded value");

  assert_no_uniform_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen_q |-> ($countones(trk_q) == 1 || $countones(trk_q) == 2))
    else $error("tracks show 000 or 111");
endmodule

// File: tb/comm_track_gen_tb.sv
module comm_track_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        angle_vld;
  logic [11:0] angle;
  logic        dir_cw;
  logic        pole_four;
  logic [7:0]  zero_ofs;
  logic        trk_u, trk_v, trk_w;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  comm_track_gen u_dut (
    .clk(clk), .rst_n(rst_n), .angle_vld(angle_vld), .angle(angle),
    .dir_cw(dir_cw), .pole_four(pole_four), .zero_ofs(zero_ofs),
    .trk_u(trk_u), .trk_v(trk_v), .trk_w(trk_w)
  );

  function automatic logic [2:0] model(int a, bit d, bit p, int z);
    int aa, s, o, e;
    logic [2:0] r;
    aa = d ? ((4096 - a) % 4096) : a;      // R8
    s  = (aa * 192) / 4096;                 // R3
    o  = (z >= 192) ? z - 192 : z;          // R6
    e  = (s - o + 192) % 192;               // R5
    if (p) e = (2 * e) % 192;               // R7
    r[0] = (e < 96);                        // R4
    r[1] = (e >= 64 && e < 160);
    r[2] = (e >= 128 || e < 32);
    return r;
  endfunction

  task automatic compare(logic [2:0] exp, string req);
    logic [2:0] act;
    act = {trk_w, trk_v, trk_u};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: wuv actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one valid sample at a falling edge, check after the next one.
  task automatic sample(int a, bit d, bit p, int z, string req);
    angle     = 12'(a);
    dir_cw    = d;
    pole_four = p;
    zero_ofs  = 8'(z);
    angle_vld = 1'b1;
    @(negedge clk);
    angle_vld = 1'b0;
    compare(model(a, d, p, z), req);
  endtask

  task automatic t_reset();
    compare(3'b000, "R1");
    angle = 12'd100; dir_cw = 1'b0; pole_four = 1'b0; zero_ofs = 8'd0;
    repeat (3) @(negedge clk);
    compare(3'b000, "R1");
  endtask

  task automatic t_two_pole();
    for (int a = 0; a < 4096; a += 61) sample(a, 1'b0, 1'b0, 0, "R4");
    sample(2047, 1'b0, 1'b0, 0, "R3");
    sample(2048, 1'b0, 1'b0, 0, "R3");
    sample(682,   1'b0, 1'b0, 0, "R4");
    sample(683,  1'b0, 1'b0, 0, "R4");
    sample(4095, 1'b0, 1'b0, 0, "R3");
  endtask

  task automatic t_offset();
    for (int a = 0; a < 4096; a += 97) sample(a, 1'b0, 1'b0, 32, "R5");
    sample(682, 1'b0, 1'b0, 32, "R5");
    sample(683, 1'b0, 1'b0, 32, "R5");
    sample(0,   1'b0, 1'b0, 191, "R5");
    sample(21,  1'b0, 1'b0, 191, "R5");
  endtask

  task automatic t_ofs_wrap();
    for (int z = 192; z < 256; z += 9) begin
      sample(40,   1'b0, 1'b0, z, "R6");
      sample(40,   1'b0, 1'b1, z, "R6");
      sample(3000, 1'b1, 1'b1, z, "R6");
    end
    sample(2048, 1'b0, 1'b0, 8'hC5, "R6");
  endtask

  task automatic t_four_pole();
    for (int a = 0; a < 4096; a += 53) sample(a, 1'b0, 1'b1, 0, "R7");
    sample(1023, 1'b0, 1'b1, 0, "R7");
    sample(1024, 1'b0, 1'b1, 0, "R7");
    sample(2048, 1'b0, 1'b1, 70, "R7");
  endtask

  task automatic t_direction();
    for (int a = 0; a < 4096; a += 79) sample(a, 1'b1, 1'b0, 0, "R8");
    sample(0,    1'b1, 1'b0, 0,  "R8");
    sample(2048, 1'b1, 1'b0, 0,  "R8");
    sample(1000, 1'b1, 1'b1, 30, "R8");
  endtask

  task automatic t_hold();
    logic [2:0] held;
    sample(500, 1'b0, 1'b0, 0, "R2");
    held = model(500, 1'b0, 1'b0, 0);
    angle = 12'd3000; dir_cw = 1'b1; pole_four = 1'b1; zero_ofs = 8'd77;
    repeat (4) @(negedge clk);
    compare(held, "R2");
    sample(3000, 1'b1, 1'b1, 77, "R2");
  endtask

  initial begin
    rst_n = 1'b0; angle_vld = 1'b0; angle = '0;
    dir_cw = 1'b0; pole_four = 1'b0; zero_ofs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_two_pole();
    t_offset();
    t_ofs_wrap();
    t_four_pole();
    t_direction();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule